// File: doc/BRIEF.md
# Byte-Lane Stream Serial Transmitter

This block takes stream words several bytes wide, each with a per-lane keep mask and an end-of-packet flag, and sends their bytes out on an asynchronous serial line. The lanes of a word go out lowest first. A lane is sent only when its keep bit is set. Each byte is framed with a start bit, eight data bits, an optional parity bit and a configurable number of stop bits.

Two fixed bytes can be added to the output by parameter. A separator byte can follow every accepted word, and a terminator byte can follow every word that closes a packet. When both apply to the same word, the separator goes out before the terminator.

Words can enter through a small FIFO, so a producer can get ahead of the line. They can also be taken directly, one at a time. In that case the input stays closed until the last stop bit of the word has left. Bit timing comes from a phase accumulator that is restarted at each start bit. Bits therefore last a whole number of cycles each, but the count varies from bit to bit, so that edge error does not build up over the frame.

Top module: `stream_uart_tx`

## Requirements
- R1: After reset the line is high and `s_ready` is high. Between frames the line stays high.
- R2: A frame is the start bit (0), then data bits 0 to 7 (least significant first), then the parity bit if enabled, then `STOP_BITS` stop bits (1). The next start bit comes no earlier than the clock after the last stop bit ends.
- R3: `PARITY` selects the parity bit. 0 sends none. 1 is odd: the data bits and the parity bit together hold an odd number of ones. 2 is even: they hold an even number of ones.
- R4: Take the edge that drives the start bit as cycle 0. The line then changes to frame bit j on cycle ceil(j*CLK_HZ/BAUD_HZ), and the frame ends on cycle ceil(N*CLK_HZ/BAUD_HZ), where N is the frame's bit count.
- R5: Lane k of `s_data` is bits 8k+7 down to 8k. The lanes of one word are sent in ascending k.
- R6: Lane k is sent only when `s_keep[k]` is 1. Lanes with a clear keep bit are skipped and produce no frame.
- R7: With `SEP_EN` = 1, `SEP_BYTE` is sent after the lanes of every accepted word, including a word whose keep mask is all zero. With `SEP_EN` = 0, no separator is sent.
- R8: With `END_EN` = 1, `END_BYTE` is sent after a word accepted with `s_last` = 1. With `END_EN` = 0, `s_last` has no effect on the line.
- R9: When a word gets both trailers, the separator is sent first and the terminator second.
- R10: With `FIFO_LOG2` = 0, `s_ready` goes low in the cycle after a word is accepted that has at least one byte to send. It stays low until the final stop bit of that word's last frame has ended. A word with nothing to send leaves `s_ready` high.
- R11: With `FIFO_LOG2` > 0, `s_ready` is high exactly when the FIFO of 2^FIFO_LOG2 words has room. From idle, a producer that keeps `s_valid` high gets 2^FIFO_LOG2 + 1 words accepted before `s_ready` first drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Block can accept a word this cycle |
| s_data | input | 8*NBYTES | Word data, lane k in bits 8k+7 down to 8k |
| s_keep | input | NBYTES | Per-lane send enable |
| s_last | input | 1 | Word closes a packet |
| tx_line | output | 1 | Serial output, idles high |

## Verification
The bench builds two instances with a reduced clock-to-baud ratio, so that frames stay short while every bit period is still fractional. The first has 100/30 cycles per bit, four lanes, a 4-word FIFO, odd parity, two stop bits and both trailers. This brings in the FIFO fill count, keep masks that skip lanes, a word made only of a separator, and a word that takes both trailers in order. The second has 100/40 cycles per bit, two lanes, no FIFO, even parity, one stop bit and no trailers. This exposes the direct-path ready timing, a keep-zero word that must leave ready high, and `s_last` having no effect. A behavioural line model predicts the level of each output on every clock from the uneven bit boundaries.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_ODD  = 2'd1,
    PAR_EVEN = 2'd2
  } parity_e;

  // Parity bit that completes the requested ones-count over data + parity.
  function automatic logic par_bit(input parity_e mode, input logic [7:0] d);
    logic x;
    x = ^d;
    return (mode == PAR_ODD) ? ~x : x;
  endfunction

endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, wp_d, rp_q, rp_d;

  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign rdata = mem[rp_q[AW-1:0]];

  always_comb begin
    wp_d = push ? wp_q + 1'b1 : wp_q;
    rp_d = pop  ? rp_q + 1'b1 : rp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q[AW-1:0]] <= wdata;
  end

  AST_FIFO_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);  // R11
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);  // R11

endmodule

// File: rtl/stx_baud.sv
module stx_baud #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int BAUD_HZ = 115_200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int AW = $clog2(CLK_HZ + BAUD_HZ + 1);
  localparam logic [AW-1:0] CLK_L  = AW'(CLK_HZ);
  localparam logic [AW-1:0] BAUD_L = AW'(BAUD_HZ);

  logic [AW-1:0] acc_q, acc_d, sum;

  assign sum  = acc_q + BAUD_L;
  assign tick = run && (sum >= CLK_L);

  always_comb begin
    acc_d = acc_q;
    if (restart)   acc_d = '0;
    else if (tick) acc_d = sum - CLK_L;
    else if (run)  acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

endmodule

// File: rtl/stx_serializer.sv
module stx_serializer
  import stx_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BAUD_HZ   = 115_200,
  parameter int PARITY    = 0,
  parameter int STOP_BITS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_vld,
  input  logic [7:0] in_byte,
  output logic       take,
  output logic       busy,
  output logic       line
);
  localparam int PB = (PARITY != 0) ? 1 : 0;
  localparam int NB = 9 + PB + STOP_BITS;
  localparam int CW = $clog2(NB + 1);

  logic          busy_q, busy_d, line_q, line_d, tick;
  logic [NB-2:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [NB-1:0] frame;

  assign take = in_vld && !busy_q;
  assign busy = busy_q;
  assign line = line_q;

  stx_baud #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy_q),
    .restart (take),
    .tick    (tick)
  );

  always_comb begin
    frame      = '1;
    frame[0]   = 1'b0;
    frame[8:1] = in_byte;
    if (PB != 0) frame[9] = par_bit(parity_e'(PARITY), in_byte);
  end

  always_comb begin
    busy_d = busy_q;
    line_d = line_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    if (take) begin
      busy_d = 1'b1;
      line_d = 1'b0;
      sh_d   = frame[NB-1:1];
      cnt_d  = CW'(NB - 1);
    end else if (tick) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        line_d = 1'b1;
      end else begin
        line_d = sh_q[0];
        sh_d   = sh_q >> 1;
        cnt_d  = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      line_q <= 1'b1;
      sh_q   <= '1;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      line_q <= line_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_IDLE_HIGH:    assert property (@(posedge clk) disable iff (!rst_n) !busy_q |-> line_q);                  // R1
  AST_START_LOW:    assert property (@(posedge clk) disable iff (!rst_n) take |=> (!line_q && busy_q));        // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) (busy_q && !tick && !take) |=> $stable(line_q)); // R4

endmodule

// File: rtl/stream_uart_tx.sv
module stream_uart_tx #(
  parameter int         CLK_HZ    = 50_000_000,
  parameter int         BAUD_HZ   = 115_200,
  parameter int         PARITY    = 0,
  parameter int         STOP_BITS = 1,
  parameter int         NBYTES    = 4,
  parameter int         FIFO_LOG2 = 2,
  parameter bit         SEP_EN    = 1'b0,
  parameter logic [7:0] SEP_BYTE  = 8'h20,
  parameter bit         END_EN    = 1'b0,
  parameter logic [7:0] END_BYTE  = 8'h0A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [8*NBYTES-1:0] s_data,
  input  logic [NBYTES-1:0]   s_keep,
  input  logic                s_last,
  output logic                tx_line
);
  localparam int DW  = 8 * NBYTES;
  localparam int LW  = DW + NBYTES + 1;
  localparam int LIW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic [NBYTES-1:0] keep_q, keep_d, ld_keep;
  logic [DW-1:0]     data_q, data_d, ld_data;
  logic              sep_q, sep_d, end_q, end_d, ld_last;
  logic              cur_busy, load, has_lane;
  logic [LIW-1:0]    lane_idx;
  logic [7:0]        byte_val;
  logic              byte_take, ser_busy;

  assign cur_busy = (|keep_q) || sep_q || end_q;
  assign has_lane = |keep_q;

  if (FIFO_LOG2 == 0) begin : g_direct
    assign s_ready = !cur_busy && !ser_busy;
    assign load    = s_valid && s_ready;
    assign ld_data = s_data;
    assign ld_keep = s_keep;
    assign ld_last = s_last;

    AST_DIRECT_READY_DROP: assert property (@(posedge clk) disable iff (!rst_i_n)
      (load && ((|s_keep) || SEP_EN || (END_EN && s_last))) |=> !s_ready);  // R10
  end else begin : g_fifo
    logic          f_full, f_empty, f_push;
    logic [LW-1:0] f_rdata;

    assign s_ready = !f_full;
    assign f_push  = s_valid && s_ready;
    assign load    = !cur_busy && !f_empty;
    assign {ld_last, ld_keep, ld_data} = f_rdata;

    stx_fifo #(.W(LW), .AW(FIFO_LOG2)) u_fifo (
      .clk   (clk),
      .rst_n (rst_i_n),
      .push  (f_push),
      .wdata ({s_last, s_keep, s_data}),
      .pop   (load),
      .rdata (f_rdata),
      .full  (f_full),
      .empty (f_empty)
    );
  end

  // lowest lane still pending
  always_comb begin
    lane_idx = '0;
    for (int i = NBYTES - 1; i >= 0; i--) begin
      if (keep_q[i]) lane_idx = LIW'(i);
    end
  end

  always_comb begin
    if (has_lane)   byte_val = data_q[8*int'(lane_idx) +: 8];
    else if (sep_q) byte_val = SEP_BYTE;
    else            byte_val = END_BYTE;
  end

  always_comb begin
    keep_d = keep_q;
    data_d = data_q;
    sep_d  = sep_q;
    end_d  = end_q;
    if (load) begin
      keep_d = ld_keep;
      data_d = ld_data;
      sep_d  = SEP_EN;
      end_d  = END_EN && ld_last;
    end else if (byte_take) begin
      if (has_lane)   keep_d[lane_idx] = 1'b0;
      else if (sep_q) sep_d = 1'b0;
      else            end_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      keep_q <= '0;
      data_q <= '0;
      sep_q  <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      keep_q <= keep_d;
      data_q <= data_d;
      sep_q  <= sep_d;
      end_q  <= end_d;
    end
  end

  stx_serializer #(
    .CLK_HZ    (CLK_HZ),
    .BAUD_HZ   (BAUD_HZ),
    .PARITY    (PARITY),
    .STOP_BITS (STOP_BITS)
  ) u_ser (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .in_vld  (cur_busy),
    .in_byte (byte_val),
    .take    (byte_take),
    .busy    (ser_busy),
    .line    (tx_line)
  );

  AST_NO_LOAD_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_i_n) load |-> !byte_take);  // R5

endmodule

// File: tb/stream_uart_tx_bench.sv
module stx_line_mon #(
  parameter int    C       = 100,
  parameter int    B       = 30,
  parameter int    PAR     = 0,
  parameter int    STOPS   = 1,
  parameter bit    CHK_RDY = 1'b0,
  parameter string NAME    = "mon"
) (
  input logic clk,
  input logic rst_n,
  input logic line,
  input logic ready
);
  localparam int PB   = (PAR != 0) ? 1 : 0;
  localparam int NBIT = 9 + PB + STOPS;

  logic [7:0] q[$];
  logic [7:0] rx[$];
  logic [7:0] cur, rxb;
  int pos = -1;
  int checks = 0;
  int fails = 0;
  int j;
  logic eb, er;
  string tag;

  function automatic int edge_of(input int k);
    return (k * C + B - 1) / B;
  endfunction

  function automatic int bit_at(input int p);
    int k = 0;
    while (edge_of(k + 1) <= p) k++;
    return k;
  endfunction

  function automatic logic exp_bit(input int k, input logic [7:0] d);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    if (k == 9 && PB != 0) return (PAR == 1) ? ~(^d) : (^d);
    return 1'b1;
  endfunction

  function automatic void push(input logic [7:0] b);
    q.push_back(b);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (pos >= 0) begin
        pos = pos + 1;
        if (pos >= edge_of(NBIT)) begin
          rx.push_back(rxb);
          pos = -1;
        end
      end
      if (pos >= 0) begin
        j  = bit_at(pos);
        eb = exp_bit(j, cur);
        tag = (j >= 1 && j <= 8) ? "R5" : ((j == 9 && PB != 0) ? "R3" : "R2");
        checks++;
        if (line !== eb) begin
          fails++;
          $display("FAIL %s R4 %s frame bit %0d cycle %0d: line=%b expected=%b", NAME, tag, j, pos, line, eb);
        end
        if (j >= 1 && j <= 8) rxb[j-1] = line;
      end else if (line === 1'b0) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL %s R6 start bit with no byte expected: line=0 expected=1", NAME);
        end else begin
          cur = q.pop_front();
          pos = 0;
        end
      end else if (line !== 1'b1) begin
        checks++;
        fails++;
        $display("FAIL %s R1 idle line=%b expected=1", NAME, line);
      end
      if (CHK_RDY) begin
        er = (pos < 0) && (q.size() == 0);
        checks++;
        if (ready !== er) begin
          fails++;
          $display("FAIL %s R10 s_ready=%b expected=%b", NAME, ready, er);
        end
      end
    end
  end
endmodule

module stream_uart_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        f_valid = 1'b0, f_last = 1'b0, f_ready, f_line;
  logic [3:0]  f_keep = '0;
  logic [31:0] f_data = '0;
  logic        n_valid = 1'b0, n_last = 1'b0, n_ready, n_line;
  logic [1:0]  n_keep = '0;
  logic [15:0] n_data = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  stream_uart_tx #(
    .CLK_HZ(100), .BAUD_HZ(30), .PARITY(1), .STOP_BITS(2), .NBYTES(4), .FIFO_LOG2(2),
    .SEP_EN(1'b1), .SEP_BYTE(8'h20), .END_EN(1'b1), .END_BYTE(8'h0A)
  ) u_stream_uart_tx (
    .clk(clk), .rst_n(rst_n), .s_valid(f_valid), .s_ready(f_ready),
    .s_data(f_data), .s_keep(f_keep), .s_last(f_last), .tx_line(f_line)
  );

  stream_uart_tx #(
    .CLK_HZ(100), .BAUD_HZ(40), .PARITY(2), .STOP_BITS(1), .NBYTES(2), .FIFO_LOG2(0),
    .SEP_EN(1'b0), .SEP_BYTE(8'h20), .END_EN(1'b0), .END_BYTE(8'h0A)
  ) u_stream_uart_tx_direct (
    .clk(clk), .rst_n(rst_n), .s_valid(n_valid), .s_ready(n_ready),
    .s_data(n_data), .s_keep(n_keep), .s_last(n_last), .tx_line(n_line)
  );

  stx_line_mon #(.C(100), .B(30), .PAR(1), .STOPS(2), .CHK_RDY(1'b0), .NAME("fifo")) u_mon_f (
    .clk(clk), .rst_n(rst_n), .line(f_line), .ready(f_ready));
  stx_line_mon #(.C(100), .B(40), .PAR(2), .STOPS(1), .CHK_RDY(1'b1), .NAME("direct")) u_mon_n (
    .clk(clk), .rst_n(rst_n), .line(n_line), .ready(n_ready));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    checks = checks + u_mon_f.checks + u_mon_n.checks;
    fails  = fails + u_mon_f.fails + u_mon_n.fails;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  // called 2 ns after a rising edge; returns 2 ns after the accepting edge
  task automatic send_f(input logic [3:0] k, input logic [31:0] d, input logic l);
    f_valid = 1'b1; f_keep = k; f_data = d; f_last = l;
    while (!f_ready) begin @(posedge clk); #2; end
    @(posedge clk); #2;
    for (int i = 0; i < 4; i++) if (k[i]) u_mon_f.push(d[8*i +: 8]);
    u_mon_f.push(8'h20);
    if (l) u_mon_f.push(8'h0A);
    f_valid = 1'b0;
  endtask

  task automatic send_n(input logic [1:0] k, input logic [15:0] d, input logic l);
    n_valid = 1'b1; n_keep = k; n_data = d; n_last = l;
    while (!n_ready) begin @(posedge clk); #2; end
    @(posedge clk); #2;
    for (int i = 0; i < 2; i++) if (k[i]) u_mon_n.push(d[8*i +: 8]);
    n_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired: actual=running expected=finished");
      summary();
    end
  end

  initial begin
    int stall_at;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(f_line === 1'b1, "R1", "fifo line after reset", f_line, 1);
    chk(f_ready === 1'b1, "R1", "fifo ready after reset", f_ready, 1);
    chk(n_line === 1'b1, "R1", "direct line after reset", n_line, 1);
    chk(n_ready === 1'b1, "R1", "direct ready after reset", n_ready, 1);
    @(posedge clk); #2;

    // FIFO fill from idle with valid held high
    stall_at = -1;
    for (int i = 0; i < 6; i++) begin
      if (!f_ready && stall_at < 0) stall_at = i;
      send_f(4'hF, 32'h03020100 + 32'h04040404 * i, 1'b0);
    end
    chk(stall_at == 5, "R11", "words accepted before first stall", stall_at, 5);
    send_f(4'b0101, 32'hA1B2C3D4, 1'b0);
    send_f(4'b1000, 32'h55667788, 1'b0);
    send_f(4'b0000, 32'hFFFFFFFF, 1'b0);
    send_f(4'b0110, 32'hDEADBEEF, 1'b1);
    while (u_mon_f.q.size() != 0 || u_mon_f.pos >= 0) @(posedge clk);
    repeat (5) @(posedge clk);
    #2;
    chk(u_mon_f.rx.size() == 40, "R7", "fifo frames received", u_mon_f.rx.size(), 40);
    if (u_mon_f.rx.size() == 40) begin
      chk(u_mon_f.rx[0] == 8'h00 && u_mon_f.rx[3] == 8'h03, "R5", "lane order word0", u_mon_f.rx[3], 8'h03);
      chk(u_mon_f.rx[4] == 8'h20, "R7", "separator after word0", u_mon_f.rx[4], 8'h20);
      chk(u_mon_f.rx[30] == 8'hD4 && u_mon_f.rx[31] == 8'hB2, "R6", "keep 0101 lanes", u_mon_f.rx[31], 8'hB2);
      chk(u_mon_f.rx[33] == 8'h55, "R6", "keep 1000 lane", u_mon_f.rx[33], 8'h55);
      chk(u_mon_f.rx[35] == 8'h20, "R7", "separator for empty word", u_mon_f.rx[35], 8'h20);
      chk(u_mon_f.rx[36] == 8'hBE && u_mon_f.rx[37] == 8'hAD, "R6", "keep 0110 lanes", u_mon_f.rx[37], 8'hAD);
      chk(u_mon_f.rx[38] == 8'h20, "R9", "separator before terminator", u_mon_f.rx[38], 8'h20);
      chk(u_mon_f.rx[39] == 8'h0A, "R8", "terminator after last", u_mon_f.rx[39], 8'h0A);
    end

    // direct path
    send_n(2'b11, 16'h3C5A, 1'b0);
    @(negedge clk);
    chk(n_ready === 1'b0, "R10", "ready low after accept", n_ready, 0);
    @(posedge clk); #2;
    send_n(2'b10, 16'h9911, 1'b1);
    send_n(2'b00, 16'hFFFF, 1'b0);
    @(negedge clk);
    chk(n_ready === 1'b1, "R10", "ready after empty word", n_ready, 1);
    @(posedge clk); #2;
    send_n(2'b01, 16'h00C3, 1'b1);
    while (u_mon_n.q.size() != 0 || u_mon_n.pos >= 0) @(posedge clk);
    repeat (5) @(posedge clk);
    #2;
    chk(u_mon_n.rx.size() == 4, "R8", "direct frames, last ignored", u_mon_n.rx.size(), 4);
    if (u_mon_n.rx.size() == 4) begin
      chk(u_mon_n.rx[0] == 8'h5A && u_mon_n.rx[1] == 8'h3C, "R5", "direct lane order", u_mon_n.rx[1], 8'h3C);
      chk(u_mon_n.rx[2] == 8'h99, "R6", "direct keep 10", u_mon_n.rx[2], 8'h99);
      chk(u_mon_n.rx[3] == 8'hC3, "R8", "no terminator in direct", u_mon_n.rx[3], 8'hC3);
    end
    chk(n_ready === 1'b1 && n_line === 1'b1, "R1", "direct idle at end", {n_ready, n_line}, 3);
    done = 1'b1;
    summary();
  end
endmodule